// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Pin-Mode Decode

This block models a byte-wide memory that can be written only once per bit. It sits behind an active-low control interface with chip enable, output enable and a program strobe. Three level flags replace the analog conditions of a real part: program voltage present, raised programming supply present, and high voltage on address bit 9. From these pins the block works out which mode applies: read, output deselect, standby, program, program inhibit, program verify or identification signature. It then either returns a stored byte or a fixed identification code, or it burns a byte into the array.

An unwritten location reads as all ones. A program operation can only clear bits, so writing the same location again merges the new byte into the old one with a bitwise AND. Each program pulse produces exactly one write, however long the pulse lasts. The tri-state output is modelled as a data bus plus an enable qualifier. While the enable is low the data bus is held at zero. The array depth is set by `ADDR_W`. The default of 11 keeps elaboration small, and 14 gives the full 16K-byte array.

Top module: `otp_mode_ctl`

## Requirements
- R1: After reset every location reads 0xFF until it is first programmed.
- R2: With `ce_n`=0, `oe_n`=0 and `pgm_n`=1, and no program voltage and no signature match, `dout_oe` is 1 and `dout` carries the byte stored at `addr` in the same cycle.
- R3: With `ce_n`=1 (standby), `dout_oe` is 0 and `dout` is 0x00, whatever `oe_n` and `pgm_n` are.
- R4: With `ce_n`=0 and `oe_n`=1 (output deselect), `dout_oe` is 0 and `dout` is 0x00.
- R5: When `vpp_hi`=1, `vcc_prog`=1 and `ce_n`=0, a high-to-low transition of `pgm_n` writes `old AND din` into `addr`. The write takes effect on the first rising clock edge that samples `pgm_n` low after it was sampled high.
- R6: No write happens when `ce_n` is high during the pulse, when `pgm_n` never falls, when `ce_n` falls while `pgm_n` is already low, or when either `vpp_hi` or `vcc_prog` is 0. While `pgm_n`=0 the outputs are disabled.
- R7: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1 (verify), the block drives the array byte at `addr`, even when `a9_hv` is set.
- R8: With `vpp_hi`=0, `a9_hv`=1, every address bit other than bits 0 and 9 at 0, and `ce_n`=0, `oe_n`=0, `pgm_n`=1, the block drives 0x98 when `addr[0]`=0 and 0xD3 when `addr[0]`=1. If any other address bit is 1, the array byte is returned instead.
- R9: Both identification codes have odd parity over all 8 bits, with bit 7 acting as the parity bit.
- R10: A program pulse held low for many cycles writes once. Changing `din` during the pulse does not alter the stored byte.
- R11: A bit that has been cleared to 0 can never return to 1 through any later program operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears the written-location map |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Program voltage present |
| vcc_prog | input | 1 | Raised programming supply present |
| a9_hv | input | 1 | High voltage on address bit 9 (signature request) |
| dout | output | 8 | Output byte, 0x00 when not driven |
| dout_oe | output | 1 | High when the outputs would be driven |

## Verification
The bench holds a program pulse low for many cycles and changes `din` in the middle of it. A design that wrote on every low cycle would store the AND of both bytes instead of the first. It reprograms an address with a byte that has ones where zeros were already burned; a plain overwrite would bring those bits back to 1. It sets `a9_hv` with an extra address bit raised, and again with program voltage present; a loose signature decode would return an identification code in place of the stored byte in both cases. It also lowers `ce_n` while `pgm_n` is already low, and pulses with either supply flag missing. A decoder that ignored the edge rule or a supply flag would burn a byte in those cases.

// File: rtl/otp_mode_ctl.sv
module otp_mode_ctl #(
  parameter int ADDR_W = 11,
  parameter int SIG_BIT = 9,
  parameter logic [7:0] MFR_CODE = 8'h98,
  parameter logic [7:0] DEV_CODE = 8'hD3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              vcc_prog,
  input  logic              a9_hv,
  output logic [7:0]        dout,
  output logic              dout_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ID_FREE = (ADDR_W'(1) << SIG_BIT) | ADDR_W'(1);

  logic [7:0]       cells [DEPTH];
  logic [DEPTH-1:0] burned;
  logic             pgm_n_q;

  wire       prog_pwr = vpp_hi & vcc_prog;
  wire       wr_fire  = rst_n & prog_pwr & ~ce_n & ~pgm_n & pgm_n_q;
  wire [7:0] cur      = burned[addr] ? cells[addr] : 8'hFF;
  wire       id_hit   = ~vpp_hi & a9_hv & ((addr & ~ID_FREE) == '0);
  wire [7:0] id_byte  = addr[0] ? DEV_CODE : MFR_CODE;

  assign dout_oe = ~ce_n & ~oe_n & pgm_n;
  assign dout    = dout_oe ? (id_hit ? id_byte : cur) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_n_q <= 1'b1;
      burned  <= '0;
    end else begin
      pgm_n_q <= pgm_n;
      if (wr_fire) burned[addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) cells[addr] <= cur & din;
  end

  assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dout_oe && dout == 8'h00));

  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> (!dout_oe && dout == 8'h00));

  assert_write_merges_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (burned[$past(addr)] && cells[$past(addr)] == ($past(cur) & $past(din))));

  assert_sig_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && id_hit) |-> (^dout));

  assert_one_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

  assert_burn_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(burned) >= $past($countones(burned)));
endmodule

// File: tb/otp_mode_ctl_bench.sv
module otp_mode_ctl_bench;
  localparam int AW = 11;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic vpp_hi = 1'b0, vcc_prog = 1'b0, a9_hv = 1'b0;
  logic [7:0] dout;
  logic dout_oe;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  otp_mode_ctl #(.ADDR_W(AW)) u_otp_mode_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi), .vcc_prog(vcc_prog),
    .a9_hv(a9_hv), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual oe/data=%h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic vpp, input logic hv,
                    input string req, input logic [7:0] exp);
    @(negedge clk);
    addr = a; vpp_hi = vpp; vcc_prog = vpp; a9_hv = hv;
    ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1;
    #1 chk(req, {dout_oe, dout}, {1'b1, exp});
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; a9_hv = 1'b0; vpp_hi = 1'b0; vcc_prog = 1'b0;
  endtask

  task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d, input logic vpp,
                       input logic vcc, input logic ce, input int len);
    @(negedge clk);
    addr = a; din = d; vpp_hi = vpp; vcc_prog = vcc; ce_n = ce; oe_n = 1'b1; pgm_n = 1'b1;
    @(negedge clk);
    pgm_n = 1'b0;
    repeat (len) @(negedge clk);
    pgm_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; vpp_hi = 1'b0; vcc_prog = 1'b0;
  endtask

  task automatic t_reset;
    #1 chk("R3 reset outputs", {dout_oe, dout}, 9'h000);
    @(negedge clk); rst_n = 1'b1;
    rd(11'h000, 1'b0, 1'b0, "R1 blank low", 8'hFF);
    rd(11'h7FF, 1'b0, 1'b0, "R1 blank top", 8'hFF);
  endtask

  task automatic t_program;
    pulse(11'h123, 8'hA5, 1'b1, 1'b1, 1'b0, 3);
    rd(11'h123, 1'b0, 1'b0, "R5 program A5", 8'hA5);
    rd(11'h124, 1'b0, 1'b0, "R2 neighbour untouched", 8'hFF);
    pulse(11'h123, 8'h5F, 1'b1, 1'b1, 1'b0, 2);
    rd(11'h123, 1'b0, 1'b0, "R11 AND merge", 8'h05);
    pulse(11'h123, 8'hFF, 1'b1, 1'b1, 1'b0, 2);
    rd(11'h123, 1'b0, 1'b0, "R11 no bit returns", 8'h05);
  endtask

  task automatic t_standby_deselect;
    @(negedge clk);
    addr = 11'h123; ce_n = 1'b1; oe_n = 1'b0; pgm_n = 1'b1;
    #1 chk("R3 standby oe low", {dout_oe, dout}, 9'h000);
    pgm_n = 1'b0;
    #1 chk("R3 standby pgm low", {dout_oe, dout}, 9'h000);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b1;
    #1 chk("R4 deselect", {dout_oe, dout}, 9'h000);
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic t_inhibit;
    pulse(11'h040, 8'h00, 1'b1, 1'b1, 1'b1, 2);
    rd(11'h040, 1'b0, 1'b0, "R6 ce high inhibit", 8'hFF);
    pulse(11'h040, 8'h00, 1'b0, 1'b1, 1'b0, 2);
    rd(11'h040, 1'b0, 1'b0, "R6 no vpp", 8'hFF);
    pulse(11'h040, 8'h00, 1'b1, 1'b0, 1'b0, 2);
    rd(11'h040, 1'b0, 1'b0, "R6 no vcc_prog", 8'hFF);
    @(negedge clk);
    addr = 11'h040; din = 8'h00; vpp_hi = 1'b1; vcc_prog = 1'b1; ce_n = 1'b1; pgm_n = 1'b0;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    #1 chk("R6 outputs off while pgm low", {dout_oe, dout}, 9'h000);
    repeat (2) @(negedge clk);
    pgm_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; vcc_prog = 1'b0;
    rd(11'h040, 1'b0, 1'b0, "R6 ce fell during low pgm", 8'hFF);
  endtask

  task automatic t_verify;
    pulse(11'h000, 8'h3C, 1'b1, 1'b1, 1'b0, 2);
    rd(11'h000, 1'b1, 1'b0, "R7 verify", 8'h3C);
    rd(11'h000, 1'b1, 1'b1, "R7 verify ignores a9_hv", 8'h3C);
    rd(11'h000, 1'b0, 1'b0, "R2 read after verify", 8'h3C);
  endtask

  task automatic t_signature;
    pulse(11'h004, 8'h5A, 1'b1, 1'b1, 1'b0, 2);
    rd(11'h000, 1'b0, 1'b1, "R8 manufacturer code", 8'h98);
    rd(11'h001, 1'b0, 1'b1, "R8 device code", 8'hD3);
    rd(11'h201, 1'b0, 1'b1, "R8 bit 9 level ignored", 8'hD3);
    rd(11'h004, 1'b0, 1'b1, "R8 extra bit reads array", 8'h5A);
    chk("R9 parity 0x98", {8'h00, ^8'h98}, 9'h001);
    chk("R9 parity 0xD3", {8'h00, ^8'hD3}, 9'h001);
  endtask

  task automatic t_long_pulse;
    @(negedge clk);
    addr = 11'h555; din = 8'hF0; vpp_hi = 1'b1; vcc_prog = 1'b1; ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); pgm_n = 1'b0;
    repeat (4) @(negedge clk);
    din = 8'h0F;
    repeat (20) @(negedge clk);
    pgm_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; vpp_hi = 1'b0; vcc_prog = 1'b0;
    rd(11'h555, 1'b0, 1'b0, "R10 one write per pulse", 8'hF0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_program();
    t_standby_deselect();
    t_inhibit();
    t_verify();
    t_signature();
    t_long_pulse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule